// File: doc/BRIEF.md
# Cascaded Strip Shift Driver

This block loads 16-bit words into four external serial-in, parallel-out chains: one chain feeds the row supply switches, and the other three feed the red, green and blue column sinks. None of the four chains gets its own clock or latch pin. Each chain's shift clock and storage latch are instead two outputs of a separate 8-bit control shift register. The block owns only seven lines: the three lines of that control register and one serial data line per chain.

A user asks for a write with a one-cycle `start`, a group index and a word. The block then runs a fixed series of control-register updates. Each update shifts a whole control byte out and latches it. One update drops the chosen chain's latch. Two updates per data bit produce a low and then a high level on that chain's clock. A last update raises the latch. A control bit that belongs to any other chain keeps its previous value for the whole write. When the write is over, `done` pulses for one cycle.

Top module: `cascade_strip_driver`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done`, `ctl_sdata`, `ctl_sclk`, `ctl_latch` and every `grp_sdata` line are 0.
- R2: A control update lasts 18 cycles. For control bit i, counted from 0 to 7 with bit 0 first, there are two cycles with `ctl_sdata` equal to bit i: `ctl_sclk` is 0 in the first of these cycles and 1 in the second. One cycle with `ctl_latch` high follows, then one cycle with every control line low. While the block is idle, all three control lines stay low.
- R3: In the latched control byte, bit 2g is the clock of group g and bit 2g+1 is its latch. Group 0 is the rows, group 1 red, group 2 green and group 3 blue. The first bit shifted in settles at control stage 0.
- R4: A write is 34 control updates sent back to back, starting in the cycle after acceptance. The first update clears the group's latch bit. Then, for each data bit, one update clears the group's clock bit and the next update sets it. The last update sets the latch bit.
- R5: The selected group's data line takes a new data bit at the start of that bit's clock-low update and holds it through the clock-high update. Data bits go out from bit 15 down to bit 0. Only one data line changes at a time, and no data line changes while the block is idle.
- R6: After `done`, the parallel output of the selected chain equals the requested word, with bit 15 in the far stage. The word is sent without inversion for every group, so a 1 turns a column sink on.
- R7: A `start` is accepted only when `busy` is low. `busy` is high from the cycle after acceptance through the last update. A `start` raised while `busy` is high has no effect.
- R8: `done` is high for exactly one cycle, the cycle after the last update. `busy` is low in that cycle, and a request can be accepted in it.
- R9: The control bits and the latched parallel outputs of the groups that were not selected stay unchanged during a write.
- R10: The control byte is remembered between writes. After a write, the selected group's clock bit and latch bit are both 1, and the next write starts from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted while idle |
| grp_sel | input | 2 | Target group: 0 rows, 1 red, 2 green, 3 blue |
| word_in | input | 16 | Word to load into the target chain |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse at the end of a write |
| ctl_sdata | output | 1 | Serial data of the control register |
| ctl_sclk | output | 1 | Shift clock of the control register |
| ctl_latch | output | 1 | Storage latch of the control register |
| grp_sdata | output | 4 | Serial data line of each group, indexed by group |

## Verification
The assertions check the cycle-level rules on every cycle: clock and latch pulses last one cycle and never overlap, the lines stay quiet while idle, at most one data line changes at a time, `busy` rises only after a `start`, and `done` is a single pulse that ends `busy`. Some properties depend on the whole control stream: the bit order inside each update, the correct bit of the shadow byte toggled for each step, the word arriving intact in the chosen chain, and the other chains left untouched. Only the bench's scenarios show these. The bench does so by decoding the pin activity into models of the external registers.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int DEF_GROUPS = 4;
    localparam int DEF_WORD_W = 16;

    // phase of one control-register update
    typedef enum logic [1:0] {
        PH_SHIFT_LO,
        PH_SHIFT_HI,
        PH_LATCH_HI,
        PH_LATCH_LO
    } ctl_phase_e;

    typedef enum logic [0:0] {
        SQ_IDLE,
        SQ_RUN
    } seq_state_e;

    // kind of control update issued at a step of a write
    typedef enum logic [1:0] {
        OP_LATCH_LOW,
        OP_CLK_LOW,
        OP_CLK_HIGH,
        OP_LATCH_HIGH
    } step_op_e;

    // step 0 drops the latch, the last step raises it, odd/even steps
    // lower/raise the chain clock for one data bit
    function automatic step_op_e op_for_step(input int unsigned step,
                                             input int unsigned last);
        if (step == 0)
            return OP_LATCH_LOW;
        else if (step == last)
            return OP_LATCH_HIGH;
        else if (step[0])
            return OP_CLK_LOW;
        else
            return OP_CLK_HIGH;
    endfunction

endpackage

// File: rtl/csd_ctl_serializer.sv
module csd_ctl_serializer
    import csd_pkg::*;
#(
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CTL_W-1:0] load_byte,
    output logic             sdata,
    output logic             sclk,
    output logic             latch,
    output logic             last_cycle
);

    localparam int BIT_W = $clog2(CTL_W);

    logic             active_q;
    ctl_phase_e       ph_q;
    logic [BIT_W-1:0] bit_q;
    logic [CTL_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            ph_q     <= PH_SHIFT_LO;
            bit_q    <= '0;
            byte_q   <= '0;
        end else if (load) begin
            active_q <= 1'b1;
            ph_q     <= PH_SHIFT_LO;
            bit_q    <= '0;
            byte_q   <= load_byte;
        end else if (active_q) begin
            case (ph_q)
                PH_SHIFT_LO: ph_q <= PH_SHIFT_HI;
                PH_SHIFT_HI: begin
                    if (bit_q == BIT_W'(CTL_W - 1)) begin
                        ph_q <= PH_LATCH_HI;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        ph_q  <= PH_SHIFT_LO;
                    end
                end
                PH_LATCH_HI: ph_q <= PH_LATCH_LO;
                PH_LATCH_LO: active_q <= 1'b0;
                default:     active_q <= 1'b0;
            endcase
        end
    end

    always_comb begin
        sdata      = 1'b0;
        sclk       = 1'b0;
        latch      = 1'b0;
        last_cycle = 1'b0;
        if (active_q) begin
            case (ph_q)
                PH_SHIFT_LO: sdata = byte_q[bit_q];
                PH_SHIFT_HI: begin
                    sdata = byte_q[bit_q];
                    sclk  = 1'b1;
                end
                PH_LATCH_HI: latch = 1'b1;
                PH_LATCH_LO: last_cycle = 1'b1;
                default:     last_cycle = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/csd_write_seq.sv
module csd_write_seq
    import csd_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int WORD_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [$clog2(GROUPS)-1:0] grp_in,
    input  logic [WORD_W-1:0]         word_in,
    input  logic                      upd_last,
    output logic                      ser_load,
    output logic [2*GROUPS-1:0]       ser_byte,
    output logic                      lane_we,
    output logic [$clog2(GROUPS)-1:0] lane_sel,
    output logic                      lane_bit,
    output logic                      busy,
    output logic                      done
);

    localparam int CTL_W      = 2 * GROUPS;
    localparam int GIDX_W     = $clog2(GROUPS);
    localparam int STEP_COUNT = 2 * WORD_W + 2;
    localparam int STEP_W     = $clog2(STEP_COUNT);
    localparam int LAST_STEP  = STEP_COUNT - 1;

    seq_state_e        st_q;
    logic [STEP_W-1:0] step_q;
    logic [GIDX_W-1:0] grp_q;
    logic [WORD_W-1:0] word_q;
    logic [CTL_W-1:0]  img_q;
    logic              done_q;

    logic              accept, advance, finish;
    logic [STEP_W-1:0] next_step;
    logic [STEP_W-1:0] pair_idx;
    logic [WORD_W-1:0] word_shifted;
    logic [GIDX_W-1:0] sel_grp;
    step_op_e          op;

    function automatic logic [CTL_W-1:0] apply_op(input logic [CTL_W-1:0] img,
                                                  input logic [GIDX_W-1:0] g,
                                                  input step_op_e o);
        logic [CTL_W-1:0] r;
        r = img;
        case (o)
            OP_LATCH_LOW:  r[2*int'(g)+1] = 1'b0;
            OP_CLK_LOW:    r[2*int'(g)]   = 1'b0;
            OP_CLK_HIGH:   r[2*int'(g)]   = 1'b1;
            OP_LATCH_HIGH: r[2*int'(g)+1] = 1'b1;
            default:       r = img;
        endcase
        return r;
    endfunction

    always_comb begin
        accept       = (st_q == SQ_IDLE) && start;
        advance      = (st_q == SQ_RUN) && upd_last && (step_q != STEP_W'(LAST_STEP));
        finish       = (st_q == SQ_RUN) && upd_last && (step_q == STEP_W'(LAST_STEP));
        next_step    = accept ? '0 : step_q + 1'b1;
        sel_grp      = accept ? grp_in : grp_q;
        op           = op_for_step(int'(next_step), LAST_STEP);
        ser_byte     = apply_op(img_q, sel_grp, op);
        ser_load     = accept || advance;
        pair_idx     = (next_step - 1'b1) >> 1;
        word_shifted = word_q << pair_idx;
        lane_bit     = word_shifted[WORD_W-1];
        lane_we      = advance && (op == OP_CLK_LOW);
        lane_sel     = grp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            step_q <= '0;
            grp_q  <= '0;
            word_q <= '0;
            img_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                st_q   <= SQ_RUN;
                step_q <= '0;
                grp_q  <= grp_in;
                word_q <= word_in;
                img_q  <= ser_byte;
            end else if (advance) begin
                step_q <= next_step;
                img_q  <= ser_byte;
            end else if (finish) begin
                st_q <= SQ_IDLE;
            end
        end
    end

    assign busy = (st_q == SQ_RUN);
    assign done = done_q;

endmodule

// File: rtl/csd_lane_bank.sv
module csd_lane_bank #(
    parameter int GROUPS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [$clog2(GROUPS)-1:0] sel,
    input  logic                      din,
    output logic [GROUPS-1:0]         lanes
);

    localparam int GIDX_W = $clog2(GROUPS);

    for (genvar g = 0; g < GROUPS; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                lanes[g] <= 1'b0;
            else if (we && (sel == GIDX_W'(g)))
                lanes[g] <= din;
        end
    end

endmodule

// File: rtl/cascade_strip_driver.sv
module cascade_strip_driver
    import csd_pkg::*;
#(
    parameter int GROUPS = DEF_GROUPS,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [$clog2(GROUPS)-1:0] grp_sel,
    input  logic [WORD_W-1:0]         word_in,
    output logic                      busy,
    output logic                      done,
    output logic                      ctl_sdata,
    output logic                      ctl_sclk,
    output logic                      ctl_latch,
    output logic [GROUPS-1:0]         grp_sdata
);

    localparam int CTL_W  = 2 * GROUPS;
    localparam int GIDX_W = $clog2(GROUPS);

    logic              ser_load;
    logic [CTL_W-1:0]  ser_byte;
    logic              upd_last;
    logic              lane_we;
    logic [GIDX_W-1:0] lane_sel;
    logic              lane_bit;

    csd_write_seq #(
        .GROUPS(GROUPS),
        .WORD_W(WORD_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .grp_in  (grp_sel),
        .word_in (word_in),
        .upd_last(upd_last),
        .ser_load(ser_load),
        .ser_byte(ser_byte),
        .lane_we (lane_we),
        .lane_sel(lane_sel),
        .lane_bit(lane_bit),
        .busy    (busy),
        .done    (done)
    );

    csd_ctl_serializer #(
        .CTL_W(CTL_W)
    ) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (ser_load),
        .load_byte (ser_byte),
        .sdata     (ctl_sdata),
        .sclk      (ctl_sclk),
        .latch     (ctl_latch),
        .last_cycle(upd_last)
    );

    csd_lane_bank #(
        .GROUPS(GROUPS)
    ) u_lanes (
        .clk  (clk),
        .rst  (rst),
        .we   (lane_we),
        .sel  (lane_sel),
        .din  (lane_bit),
        .lanes(grp_sdata)
    );

endmodule

// File: rtl/cascade_strip_driver_chk.sv
module cascade_strip_driver_chk #(
    parameter int GROUPS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              ctl_sdata,
    input logic              ctl_sclk,
    input logic              ctl_latch,
    input logic [GROUPS-1:0] grp_sdata
);

    a_r2_clk_latch_apart: assert property (@(posedge clk) disable iff (rst)
        !(ctl_sclk && ctl_latch));

    a_r2_sclk_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ctl_sclk |=> !ctl_sclk);

    a_r2_latch_one_cycle: assert property (@(posedge clk) disable iff (rst)
        ctl_latch |=> !ctl_latch);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ctl_sclk && !ctl_latch && !ctl_sdata));

    a_r5_lanes_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(grp_sdata));

    a_r5_one_lane_moves: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grp_sdata ^ $past(grp_sdata)));

    a_r7_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

endmodule

bind cascade_strip_driver cascade_strip_driver_chk #(
    .GROUPS(GROUPS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ctl_sdata(ctl_sdata),
    .ctl_sclk (ctl_sclk),
    .ctl_latch(ctl_latch),
    .grp_sdata(grp_sdata)
);

// File: tb/cascade_strip_driver_test.sv
module cascade_strip_driver_test;

    localparam int CLK_PERIOD = 10;
    localparam int GROUPS     = 4;
    localparam int WORD_W     = 16;
    localparam int CTL_W      = 2 * GROUPS;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [1:0]        grp_sel = '0;
    logic [WORD_W-1:0] word_in = '0;
    logic              busy, done, ctl_sdata, ctl_sclk, ctl_latch;
    logic [GROUPS-1:0] grp_sdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cascade_strip_driver uut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .grp_sel  (grp_sel),
        .word_in  (word_in),
        .busy     (busy),
        .done     (done),
        .ctl_sdata(ctl_sdata),
        .ctl_sclk (ctl_sclk),
        .ctl_latch(ctl_latch),
        .grp_sdata(grp_sdata)
    );

    typedef struct packed {
        logic              sd;
        logic              sc;
        logic              la;
        logic [GROUPS-1:0] lanes;
        logic              busy;
        logic              done;
    } exp_t;

    exp_t q[$];
    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    bit   run_chk = 0;
    bit   finished = 0;

    // expected-stream model state
    logic [CTL_W-1:0]  mdl_img = '0;
    logic [GROUPS-1:0] mdl_lanes = '0;

    // models of the external registers, driven only by the pins
    logic [CTL_W-1:0]  creg = '0, cout = '0, prev_cout = '0;
    logic [WORD_W-1:0] chain [GROUPS];
    logic [WORD_W-1:0] cpar  [GROUPS];
    logic [WORD_W-1:0] snap_par [GROUPS];
    logic [CTL_W-1:0]  snap_cout = '0;
    logic              prev_sclk = 1'b0, prev_latch = 1'b0;
    bit                pend = 0;
    int                pend_g = 0;
    logic [WORD_W-1:0] pend_w = '0;

    initial begin
        for (int g = 0; g < GROUPS; g++) begin
            chain[g]    = '0;
            cpar[g]     = '0;
            snap_par[g] = '0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push_update(input logic [CTL_W-1:0] b);
        for (int i = 0; i < CTL_W; i++) begin
            q.push_back('{sd: b[i], sc: 1'b0, la: 1'b0, lanes: mdl_lanes, busy: 1'b1, done: 1'b0});
            q.push_back('{sd: b[i], sc: 1'b1, la: 1'b0, lanes: mdl_lanes, busy: 1'b1, done: 1'b0});
        end
        q.push_back('{sd: 1'b0, sc: 1'b0, la: 1'b1, lanes: mdl_lanes, busy: 1'b1, done: 1'b0});
        q.push_back('{sd: 1'b0, sc: 1'b0, la: 1'b0, lanes: mdl_lanes, busy: 1'b1, done: 1'b0});
    endtask

    // R4 step order, R5 MSB-first data, R10 shadow byte carried over
    task automatic push_write(input int g, input logic [WORD_W-1:0] w);
        mdl_img[2*g+1] = 1'b0;
        push_update(mdl_img);
        for (int k = WORD_W - 1; k >= 0; k--) begin
            mdl_lanes[g] = w[k];
            mdl_img[2*g] = 1'b0;
            push_update(mdl_img);
            mdl_img[2*g] = 1'b1;
            push_update(mdl_img);
        end
        mdl_img[2*g+1] = 1'b1;
        push_update(mdl_img);
        q.push_back('{sd: 1'b0, sc: 1'b0, la: 1'b0, lanes: mdl_lanes, busy: 1'b0, done: 1'b1});
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (run_chk && !finished) begin
            exp_t e;
            bit   idle_now;
            cyc++;
            if (cyc > WATCHDOG) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired at cycle %0d", cyc);
                finish_run();
            end
            // R3: decode the pins into the external registers
            if (ctl_sclk && !prev_sclk) creg = {ctl_sdata, creg[CTL_W-1:1]};
            if (ctl_latch && !prev_latch) cout = creg;
            for (int g = 0; g < GROUPS; g++) begin
                if (cout[2*g] && !prev_cout[2*g])
                    chain[g] = {chain[g][WORD_W-2:0], grp_sdata[g]};
                if (cout[2*g+1] && !prev_cout[2*g+1])
                    cpar[g] = chain[g];
            end
            prev_sclk  = ctl_sclk;
            prev_latch = ctl_latch;
            prev_cout  = cout;

            // cycle-by-cycle comparison with the expected stream
            if (q.size() > 0)
                e = q.pop_front();
            else
                e = '{sd: 1'b0, sc: 1'b0, la: 1'b0, lanes: mdl_lanes, busy: 1'b0, done: 1'b0};
            check({ctl_sdata, ctl_sclk, ctl_latch} == {e.sd, e.sc, e.la}, "R2", "control lines",
                  32'({ctl_sdata, ctl_sclk, ctl_latch}), 32'({e.sd, e.sc, e.la}));
            check(grp_sdata == e.lanes, "R5", "group data lines", 32'(grp_sdata), 32'(e.lanes));
            check(busy == e.busy, "R7", "busy", 32'(busy), 32'(e.busy));
            check(done == e.done, "R8", "done", 32'(done), 32'(e.done));
            idle_now = !e.busy;

            // end-of-write content checks
            if (e.done && pend) begin
                pend = 0;
                check(cpar[pend_g] == pend_w, "R6", "target chain word", 32'(cpar[pend_g]), 32'(pend_w));
                check(cout[2*pend_g] && cout[2*pend_g+1], "R10", "target clock/latch bits",
                      32'(cout), 32'(snap_cout | (CTL_W'(3) << (2*pend_g))));
                for (int g = 0; g < GROUPS; g++) begin
                    if (g != pend_g) begin
                        check(cpar[g] == snap_par[g], "R9", "other chain output",
                              32'(cpar[g]), 32'(snap_par[g]));
                        check(cout[2*g +: 2] == snap_cout[2*g +: 2], "R9", "other control bits",
                              32'(cout[2*g +: 2]), 32'(snap_cout[2*g +: 2]));
                    end
                end
            end

            // acceptance at the coming edge
            if (start && idle_now) begin
                pend   = 1;
                pend_g = int'(grp_sel);
                pend_w = word_in;
                snap_cout = cout;
                for (int g = 0; g < GROUPS; g++) snap_par[g] = cpar[g];
                push_write(int'(grp_sel), word_in);
            end
        end
    end

    task automatic wait_done;
        do begin
            @(posedge clk);
            #1;
        end while (!done);
    endtask

    task automatic do_write(input int g, input logic [WORD_W-1:0] w);
        start   = 1'b1;
        grp_sel = 2'(g);
        word_in = w;
        do begin
            @(posedge clk);
            #1;
        end while (!busy);
        start = 1'b0;
        wait_done();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check({busy, done, ctl_sdata, ctl_sclk, ctl_latch} == 5'b0, "R1", "status/control in reset",
              32'({busy, done, ctl_sdata, ctl_sclk, ctl_latch}), 32'(0));
        check(grp_sdata == '0, "R1", "data lines in reset", 32'(grp_sdata), 32'(0));
        rst = 1'b0;
        run_chk = 1;
        repeat (4) @(posedge clk);
        #1;

        do_write(0, 16'hA5C3);
        repeat (5) @(posedge clk);
        #1;
        do_write(2, 16'h0001);

        // R7: requests raised while busy are ignored
        start   = 1'b1;
        grp_sel = 2'd3;
        word_in = 16'h8000;
        do begin
            @(posedge clk);
            #1;
        end while (!busy);
        start = 1'b0;
        repeat (100) @(posedge clk);
        #1;
        start   = 1'b1;
        grp_sel = 2'd1;
        word_in = 16'h1234;
        repeat (20) @(posedge clk);
        #1;
        start = 1'b0;
        wait_done();

        // R8: request held through a write is taken in the done cycle
        start   = 1'b1;
        grp_sel = 2'd1;
        word_in = 16'hFFFF;
        do begin
            @(posedge clk);
            #1;
        end while (!busy);
        grp_sel = 2'd0;
        word_in = 16'h0F0F;
        wait_done();
        @(posedge clk);
        #1;
        start = 1'b0;
        wait_done();

        do_write(3, 16'h0000);
        do_write(1, 16'h8001);
        do_write(2, 16'hC3A5);
        repeat (10) @(posedge clk);
        #1;
        finish_run();
    end

endmodule